// File: doc/BRIEF.md
# Panel Row Readout Sequencer

This block produces the timing that reads one frame out of a flat-panel X-ray detector, one row after another. After a frame start it selects row 0, clears the column front-ends, and takes a baseline sample. It then opens the row gate so the pixel charge reaches the column line, and closes the gate one cycle before the sample window ends. Last, it runs one conversion and one data-valid beat for each column group, with a multiplexer select that lets a few converters serve many columns. When the last row is done it raises a one-cycle end-of-frame pulse and goes back to idle.

An exposure inhibit input freezes the scan while the pixels integrate. No row gate and no column strobe is driven during that time, and the sequence resumes exactly where it stopped. The phase lengths and the number of column groups come from configuration inputs. They are captured when a frame is accepted, so a change in mid-frame does not disturb the frame in progress. A frame start that arrives while a frame is running is dropped and recorded in a sticky flag.

Top module: `panel_row_sequencer`

## Requirements
- R1: A frame start seen in idle begins the scan at row 0 on the next cycle. Rows follow in order 0, 1, ..., ROWS-1, with `row_idx` rising by exactly one at each row change, and only one row is selected at a time.
- R2: While `expose_inhibit` is high, `row_gate`, `col_reset`, `col_sample`, `adc_convert` and `data_valid` are low in that same cycle. A scan in progress holds its row, group and position in the phase, and resumes from that point once the inhibit drops.
- R3: Each row runs its phases in a fixed order. First `col_reset` is high for Lr cycles. Then `col_sample` is high for Ls+Lg+1 cycles. Then, for each column group, `adc_convert` is high for Lc cycles and `data_valid` is high for 1 cycle. At most one of these strobes and `end_of_frame` is high in any cycle.
- R4: Within the sample window, `row_gate` is high on offsets Ls to Ls+Lg-1, counting from 0. It is low on the final offset, so the gate is removed one cycle before the sample strobe ends.
- R5: `mux_sel` holds the group number, counting 0 to G-1, during that group's convert and data-valid cycles. It is 0 during reset and sample.
- R6: The lengths Lr, Ls, Lg and Lc and the group count G are taken from the configuration inputs in the cycle the frame start is accepted, with a value of 0 treated as 1. Later changes have no effect until the next accepted frame.
- R7: `end_of_frame` is high for exactly one cycle, ROWS*(Lr+Ls+Lg+1+G*(Lc+1)) cycles after the first reset cycle. During that cycle `row_idx` shows ROWS-1. The block is idle on the next cycle, with `row_idx` back at 0.
- R8: A frame start that arrives while a frame is running, including during the end-of-frame cycle, leaves the scan unchanged and sets `overrun`. `overrun` stays high until reset.
- R9: After reset all strobes are low, and `row_idx`, `mux_sel` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Request to read one frame |
| expose_inhibit | input | 1 | High while the panel integrates; freezes the scan |
| cfg_reset_len | input | LEN_W | Column reset length Lr |
| cfg_sample_len | input | LEN_W | Baseline sample length Ls before the gate opens |
| cfg_gate_len | input | LEN_W | Row gate on length Lg |
| cfg_conv_len | input | LEN_W | Conversion length Lc per group |
| cfg_groups | input | GRP_W | Column group count G |
| row_gate | output | 1 | Gate enable for the selected row |
| row_idx | output | ROW_W | Index of the selected row |
| col_reset | output | 1 | Column front-end reset strobe |
| col_sample | output | 1 | Correlated double sampling strobe |
| adc_convert | output | 1 | Converter start strobe |
| mux_sel | output | GRP_W | Column group select |
| data_valid | output | 1 | Converted group data is valid |
| end_of_frame | output | 1 | One-cycle pulse after the last row |
| overrun | output | 1 | Sticky: a frame start was dropped |

## Verification
Several properties are checked on every cycle. The row index only rises by one or returns to 0. An inhibit blocks the gate and freezes the scan. Phases only follow their fixed order, at most one strobe is high, and the gate is low in the last sample cycle. The group select is stable across data valid, end-of-frame is a single pulse, and the overrun flag is sticky. Some properties can only be shown by the bench's scenarios. These are the exact phase lengths and cycle positions, the treatment of zero lengths as one, the capture of the configuration at frame start, and the total frame duration. Resuming at the same point after random inhibit stretches and dropping a start request in mid-frame also need the scenarios. The bench compares each of these cycle by cycle against a timeline it computes itself.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RST  = 3'd1,
    PH_SMP  = 3'd2,
    PH_CNV  = 3'd3,
    PH_DV   = 3'd4,
    PH_EOF  = 3'd5
  } phase_e;

  // phases that the exposure inhibit is allowed to freeze
  function automatic logic is_scan(input phase_e p);
    return (p == PH_RST) || (p == PH_SMP) || (p == PH_CNV) || (p == PH_DV);
  endfunction

endpackage

// File: rtl/seq_cfg_shadow.sv
module seq_cfg_shadow #(
  parameter int LEN_W = 4,
  parameter int GRP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] in_reset_len,
  input  logic [LEN_W-1:0] in_sample_len,
  input  logic [LEN_W-1:0] in_gate_len,
  input  logic [LEN_W-1:0] in_conv_len,
  input  logic [GRP_W-1:0] in_groups,
  output logic [LEN_W-1:0] r_len,
  output logic [LEN_W-1:0] s_len,
  output logic [LEN_W-1:0] g_len,
  output logic [LEN_W-1:0] c_len,
  output logic [GRP_W-1:0] n_grp
);

  // R6: a zero length becomes one cycle
  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
    return (v == '0) ? LEN_W'(1) : v;
  endfunction

  function automatic logic [GRP_W-1:0] clamp_grp(input logic [GRP_W-1:0] v);
    return (v == '0) ? GRP_W'(1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_len <= LEN_W'(1);
      s_len <= LEN_W'(1);
      g_len <= LEN_W'(1);
      c_len <= LEN_W'(1);
      n_grp <= GRP_W'(1);
    end else if (load) begin
      r_len <= clamp_len(in_reset_len);
      s_len <= clamp_len(in_sample_len);
      g_len <= clamp_len(in_gate_len);
      c_len <= clamp_len(in_conv_len);
      n_grp <= clamp_grp(in_groups);
    end
  end

  // R6: the shadow never holds a zero length
  p_nonzero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_len != '0) && (s_len != '0) && (g_len != '0) && (c_len != '0) && (n_grp != '0));

endmodule

// File: rtl/seq_phase_counter.sv
module seq_phase_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             hold,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  assign last = (cnt == (limit - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (restart)          cnt <= '0;
    else if (!hold && !last)   cnt <= cnt + CNT_W'(1);
  end

  // R3: the position never runs past the length of the current phase
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < limit);

  // R2: a held counter does not move
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !restart) |=> $stable(cnt));

endmodule

// File: rtl/seq_strobe_decode.sv
module seq_strobe_decode
  import panel_seq_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int GRP_W = 3,
  parameter int CNT_W = 6
) (
  input  phase_e           phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic [LEN_W-1:0] s_len,
  input  logic [LEN_W-1:0] g_len,
  input  logic [GRP_W-1:0] grp,
  input  logic             inhibit,
  output logic             gate_win,
  output logic             row_gate,
  output logic             col_reset,
  output logic             col_sample,
  output logic             adc_convert,
  output logic             data_valid,
  output logic             end_of_frame,
  output logic [GRP_W-1:0] mux_sel
);

  logic [CNT_W-1:0] gate_open_at;
  logic [CNT_W-1:0] gate_close_at;

  // gate window is [Ls, Ls+Lg) inside the sample phase
  assign gate_open_at  = CNT_W'(s_len);
  assign gate_close_at = CNT_W'(s_len) + CNT_W'(g_len);
  assign gate_win      = (phase == PH_SMP) && (cnt >= gate_open_at) && (cnt < gate_close_at);

  always_comb begin
    row_gate     = gate_win && !inhibit;
    col_reset    = (phase == PH_RST) && !inhibit;
    col_sample   = (phase == PH_SMP) && !inhibit;
    adc_convert  = (phase == PH_CNV) && !inhibit;
    data_valid   = (phase == PH_DV)  && !inhibit;
    end_of_frame = (phase == PH_EOF);
    mux_sel      = ((phase == PH_CNV) || (phase == PH_DV)) ? grp : '0;
  end

endmodule

// File: rtl/panel_row_sequencer.sv
module panel_row_sequencer
  import panel_seq_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int LEN_W = 4,
  parameter int GRP_W = 3,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CNT_W = LEN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             expose_inhibit,
  input  logic [LEN_W-1:0] cfg_reset_len,
  input  logic [LEN_W-1:0] cfg_sample_len,
  input  logic [LEN_W-1:0] cfg_gate_len,
  input  logic [LEN_W-1:0] cfg_conv_len,
  input  logic [GRP_W-1:0] cfg_groups,
  output logic             row_gate,
  output logic [ROW_W-1:0] row_idx,
  output logic             col_reset,
  output logic             col_sample,
  output logic             adc_convert,
  output logic [GRP_W-1:0] mux_sel,
  output logic             data_valid,
  output logic             end_of_frame,
  output logic             overrun
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  // sample window spans baseline, gate-on and one gate-off cycle
  function automatic logic [CNT_W-1:0] smp_span(input logic [LEN_W-1:0] s,
                                                input logic [LEN_W-1:0] g);
    return CNT_W'(s) + CNT_W'(g) + CNT_W'(1);
  endfunction

  phase_e           phase_q;
  logic [ROW_W-1:0] row_q;
  logic [GRP_W-1:0] grp_q;
  logic             ovr_q;

  logic [LEN_W-1:0] r_len, s_len, g_len, c_len;
  logic [GRP_W-1:0] n_grp;
  logic [CNT_W-1:0] ph_limit, ph_cnt;
  logic             ph_last;

  // named internal events
  logic active, accept, stall, step, restart, last_grp, last_row, gate_win;

  assign active   = (phase_q != PH_IDLE);
  assign accept   = frame_start && !active;
  assign stall    = expose_inhibit && is_scan(phase_q);
  assign step     = active && ph_last && !stall;
  assign restart  = accept || step;
  assign last_grp = (grp_q == (n_grp - GRP_W'(1)));
  assign last_row = (row_q == LAST_ROW);

  seq_cfg_shadow #(.LEN_W(LEN_W), .GRP_W(GRP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .in_reset_len(cfg_reset_len), .in_sample_len(cfg_sample_len),
    .in_gate_len(cfg_gate_len), .in_conv_len(cfg_conv_len), .in_groups(cfg_groups),
    .r_len(r_len), .s_len(s_len), .g_len(g_len), .c_len(c_len), .n_grp(n_grp)
  );

  always_comb begin
    unique case (phase_q)
      PH_RST:  ph_limit = CNT_W'(r_len);
      PH_SMP:  ph_limit = smp_span(s_len, g_len);
      PH_CNV:  ph_limit = CNT_W'(c_len);
      default: ph_limit = CNT_W'(1);
    endcase
  end

  seq_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .hold(stall),
    .limit(ph_limit), .cnt(ph_cnt), .last(ph_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      grp_q   <= '0;
    end else if (accept) begin
      phase_q <= PH_RST;
      row_q   <= '0;
      grp_q   <= '0;
    end else if (step) begin
      unique case (phase_q)
        PH_RST: phase_q <= PH_SMP;
        PH_SMP: begin
          phase_q <= PH_CNV;
          grp_q   <= '0;
        end
        PH_CNV: phase_q <= PH_DV;
        PH_DV: begin
          if (!last_grp) begin
            phase_q <= PH_CNV;
            grp_q   <= grp_q + GRP_W'(1);
          end else if (!last_row) begin
            phase_q <= PH_RST;
            row_q   <= row_q + ROW_W'(1);
            grp_q   <= '0;
          end else begin
            phase_q <= PH_EOF;
            grp_q   <= '0;
          end
        end
        PH_EOF: begin
          phase_q <= PH_IDLE;
          row_q   <= '0;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      ovr_q <= 1'b0;
    else if (frame_start && active)  ovr_q <= 1'b1;
  end

  seq_strobe_decode #(.LEN_W(LEN_W), .GRP_W(GRP_W), .CNT_W(CNT_W)) u_dec (
    .phase(phase_q), .cnt(ph_cnt), .s_len(s_len), .g_len(g_len), .grp(grp_q),
    .inhibit(expose_inhibit), .gate_win(gate_win),
    .row_gate(row_gate), .col_reset(col_reset), .col_sample(col_sample),
    .adc_convert(adc_convert), .data_valid(data_valid),
    .end_of_frame(end_of_frame), .mux_sel(mux_sel)
  );

  assign row_idx = row_q;
  assign overrun = ovr_q;

  // ---------------- assertions ----------------
  p_row_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (row_q != $past(row_q)) |-> ((row_q == $past(row_q) + ROW_W'(1)) || (row_q == '0)));

  p_row_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (row_q == '0) && (phase_q == PH_RST));

  p_inhibit_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expose_inhibit |-> !row_gate && !col_sample && !adc_convert);

  p_inhibit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(phase_q) && $stable(row_q) && $stable(grp_q));

  p_order_smp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SMP && $past(phase_q) != PH_SMP) |-> ($past(phase_q) == PH_RST));

  p_order_cnv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CNV && $past(phase_q) != PH_CNV)
      |-> ($past(phase_q) == PH_SMP || $past(phase_q) == PH_DV));

  p_order_dv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DV && $past(phase_q) != PH_DV) |-> ($past(phase_q) == PH_CNV));

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({col_reset, col_sample, adc_convert, data_valid, end_of_frame}));

  p_gate_off_before_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SMP && ph_last) |-> !gate_win);

  p_mux_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DV) |-> $stable(mux_sel));

  p_eof_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    end_of_frame |=> !end_of_frame && (phase_q == PH_IDLE) && (row_q == '0));

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && active) |=> overrun);

endmodule

// File: tb/tb_panel_row_sequencer.sv
module tb_panel_row_sequencer;

  localparam int ROWS    = 8;
  localparam int LEN_W   = 4;
  localparam int GRP_W   = 3;
  localparam int ROW_W   = $clog2(ROWS);
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic expose_inhibit = 1'b0;
  logic [LEN_W-1:0] cfg_reset_len = '0, cfg_sample_len = '0, cfg_gate_len = '0, cfg_conv_len = '0;
  logic [GRP_W-1:0] cfg_groups = '0;
  logic row_gate, col_reset, col_sample, adc_convert, data_valid, end_of_frame, overrun;
  logic [ROW_W-1:0] row_idx;
  logic [GRP_W-1:0] mux_sel;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  panel_row_sequencer #(.ROWS(ROWS), .LEN_W(LEN_W), .GRP_W(GRP_W)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .expose_inhibit(expose_inhibit),
    .cfg_reset_len(cfg_reset_len), .cfg_sample_len(cfg_sample_len), .cfg_gate_len(cfg_gate_len),
    .cfg_conv_len(cfg_conv_len), .cfg_groups(cfg_groups),
    .row_gate(row_gate), .row_idx(row_idx), .col_reset(col_reset), .col_sample(col_sample),
    .adc_convert(adc_convert), .mux_sel(mux_sel), .data_valid(data_valid),
    .end_of_frame(end_of_frame), .overrun(overrun)
  );

  typedef struct packed {
    logic gate, rs, sm, cv, dv, eof;
    int unsigned row, mux;
  } exp_t;

  // latched frame settings (bench view of R6)
  int unsigned lr, ls, lg, lc, ng;

  function automatic int unsigned one_min(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned row_cycles();
    return lr + ls + lg + 1 + ng * (lc + 1);
  endfunction

  // expected outputs at scan position t (t counts non-frozen cycles from the first reset cycle)
  function automatic exp_t expect_at(input int unsigned t, input bit inh);
    exp_t e;
    int unsigned rl, w, o, k, m;
    e = '0;
    rl = row_cycles();
    if (t > ROWS * rl) return e;
    if (t == ROWS * rl) begin
      e.eof = 1'b1;
      e.row = ROWS - 1;
      return e;
    end
    e.row = t / rl;
    w = t % rl;
    if (w < lr) e.rs = 1'b1;
    else if (w < lr + ls + lg + 1) begin
      e.sm = 1'b1;
      o = w - lr;
      e.gate = (o >= ls) && (o < ls + lg);
    end else begin
      k = w - lr - ls - lg - 1;
      e.mux = k / (lc + 1);
      m = k % (lc + 1);
      if (m < lc) e.cv = 1'b1;
      else e.dv = 1'b1;
    end
    if (inh) begin
      e.gate = 0; e.rs = 0; e.sm = 0; e.cv = 0; e.dv = 0;
    end
    return e;
  endfunction

  task automatic chk(input string req, input string what, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // one frame; tag names the requirement the scenario targets
  task automatic run_frame(input string tag, input int unsigned r, input int unsigned s,
                           input int unsigned g, input int unsigned c, input int unsigned n,
                           input bit use_inh, input bit poke, input bit scramble,
                           inout bit ovr_exp);
    int unsigned t = 0;
    int unsigned guard = 0;
    int unsigned fl;
    bit inh;
    bit poked;
    exp_t e;
    @(negedge clk);
    cfg_reset_len = LEN_W'(r); cfg_sample_len = LEN_W'(s); cfg_gate_len = LEN_W'(g);
    cfg_conv_len = LEN_W'(c); cfg_groups = GRP_W'(n);
    lr = one_min(r); ls = one_min(s); lg = one_min(g); lc = one_min(c); ng = one_min(n);
    expose_inhibit = 1'b0;
    frame_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_start = 1'b0;
    fl = ROWS * row_cycles();
    while (t <= fl + 1 && guard < 20000) begin
      guard++;
      inh = use_inh && (t < fl) && ($urandom % 4 == 0);
      expose_inhibit = inh;
      poked = poke && (t == fl / 2) && !inh;
      frame_start = poked;
      if (scramble) begin
        cfg_reset_len = LEN_W'($urandom); cfg_sample_len = LEN_W'($urandom);
        cfg_gate_len = LEN_W'($urandom); cfg_conv_len = LEN_W'($urandom);
        cfg_groups = GRP_W'($urandom);
      end
      #1;
      e = expect_at(t, inh);
      chk(inh ? "R2" : "R4", {tag, " row_gate"}, row_gate, e.gate);
      chk(inh ? "R2" : "R3", {tag, " col_reset"}, col_reset, e.rs);
      chk(inh ? "R2" : "R3", {tag, " col_sample"}, col_sample, e.sm);
      chk(inh ? "R2" : "R3", {tag, " adc_convert"}, adc_convert, e.cv);
      chk(inh ? "R2" : "R3", {tag, " data_valid"}, data_valid, e.dv);
      chk("R7", {tag, " end_of_frame"}, end_of_frame, e.eof);
      chk("R1", {tag, " row_idx"}, row_idx, e.row);
      chk("R5", {tag, " mux_sel"}, mux_sel, e.mux);
      chk("R8", {tag, " overrun"}, overrun, ovr_exp);
      @(posedge clk);
      if (poked) ovr_exp = 1'b1;
      if (!inh) t++;
      @(negedge clk);
      frame_start = 1'b0;
    end
    expose_inhibit = 1'b0;
  endtask

  initial begin
    bit ovr = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: reset state
    chk("R9", "row_gate", row_gate, 0);
    chk("R9", "col_reset", col_reset, 0);
    chk("R9", "col_sample", col_sample, 0);
    chk("R9", "adc_convert", adc_convert, 0);
    chk("R9", "data_valid", data_valid, 0);
    chk("R9", "end_of_frame", end_of_frame, 0);
    chk("R9", "row_idx", row_idx, 0);
    chk("R9", "mux_sel", mux_sel, 0);
    chk("R9", "overrun", overrun, 0);

    // R3 / R4 / R5 / R1 / R7: directed nominal frame
    run_frame("R3 nominal", 2, 2, 3, 2, 3, 0, 0, 0, ovr);
    // R6: all-zero settings behave as one cycle and one group
    run_frame("R6 zeros", 0, 0, 0, 0, 0, 0, 0, 0, ovr);
    // R4: single-cycle gate with long baseline; R5: seven groups
    run_frame("R4 short gate", 1, 9, 1, 3, 7, 0, 0, 0, ovr);
    // R6: settings scrambled in mid-frame must not matter
    run_frame("R6 latched", 3, 1, 2, 1, 2, 0, 0, 1, ovr);
    // R2: random exposure inhibit stretches
    for (int i = 0; i < 3; i++)
      run_frame("R2 inhibit", $urandom % 16, $urandom % 16, $urandom % 16,
                $urandom % 16, $urandom % 8, 1, 0, 0, ovr);
    // R8: frame start in mid-frame is ignored and recorded
    run_frame("R8 overrun", 1, 2, 2, 2, 2, 0, 1, 0, ovr);
    // R8: flag stays set through a later frame; mixed random frame
    run_frame("R8 sticky", $urandom % 16, $urandom % 16, $urandom % 16,
              $urandom % 16, $urandom % 8, 1, 0, 1, ovr);
    // R1: back-to-back start right after idle
    run_frame("R1 restart", 1, 1, 1, 1, 1, 0, 0, 0, ovr);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule